// File: doc/BRIEF.md
# Per-Pin Programmable Interrupt Detector for an 8-Bit Input Port

This block watches up to eight pad inputs and turns activity on them into interrupt requests. Each pad is first brought into the clock domain through a synchronizer chain. Three control bits per pin then pick the trigger: a sense bit chooses edge or level detection, a dual bit makes an edge pin fire on every transition, and a polarity bit chooses falling/low or rising/high. Each pin that triggers raises a raw status bit. A per-pin enable bit gates raw status into a masked status, and the OR of all masked bits drives a single interrupt line.

Software reaches the block through a small register port. A write strobe, a 3-bit address and an 8-bit data bus load the control and enable registers and the clear register. A combinational read bus returns the control registers and both status views. A build parameter lists the pins that have a pad. Positions without a pad accept no writes, read as zero and never raise status.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every sense, dual, polarity and enable bit is 0 and raw status is 0. So every pin is a masked, single falling-edge pin and `irq_out` is low.
- R2: With the default two-stage synchronizer, a pad change that meets a rising clock edge shows in raw status on the third rising edge, counting that edge as the first. It is not visible after the second.
- R3: On a pin whose sense bit is 0 (edge) and dual bit is 0, a polarity of 1 sets raw status on a 0-to-1 transition, and a polarity of 0 sets it on a 1-to-0 transition. The other transition leaves raw status unchanged.
- R4: On an edge pin whose dual bit is 1, both transitions set raw status and the polarity bit has no effect. The dual bit has no effect on a level pin.
- R5: Raw status of an edge pin is sticky. It clears only when a 1 is written to that bit position of the clear register at address 6. Bits written as 0 leave their status unchanged.
- R6: On a pin whose sense bit is 1 (level), raw status equals 1 while the synchronized pin equals the polarity bit and 0 otherwise. Writes to the clear register do not affect it.
- R7: Masked status (read at address 5) is raw status AND the enable register. `irq_out` is 1 exactly when any masked status bit is 1.
- R8: For a bit position whose pad is absent (cleared in `CONN_MASK`), register writes have no effect, reads return 0 and raw status stays 0.
- R9: If an edge event on a pin and a clear write to that pin take effect on the same clock edge, the event wins and raw status stays 1.
- R10: Register map (3-bit address): 0 sense, 1 dual, 2 polarity, 3 enable, all read/write. 4 raw status and 5 masked status are read-only. 6 clear is write-only and reads 0. 7 reads 0.
- R11: A change of sense, dual or polarity is not filtered. A level pin shows the new level comparison at once, and a pin switched from level to edge keeps its last raw value until cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pad_in | input | NPINS | Asynchronous pad levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Combined interrupt, OR of masked status |

## Verification
The hardest case to reach from the ports is an edge event and a clear write that land on the same clock edge. The event appears only after the synchronizer delay, so a directed sequence times the clear write to the exact cycle in which the delayed transition is detected. The rest of the stimulus is a seeded random mix of pad changes, control writes and clear writes. Each one lets the pipeline settle before raw status, masked status and `irq_out` are compared with a transaction-level model. That mix produces mode switches on pins with live status, the case that R11 covers.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    RA_SENSE  = 3'd0,
    RA_DUAL   = 3'd1,
    RA_POL    = 3'd2,
    RA_ENABLE = 3'd3,
    RA_RAW    = 3'd4,
    RA_MASKED = 3'd5,
    RA_CLEAR  = 3'd6,
    RA_NONE   = 3'd7
  } reg_sel_e;

  // Transition qualifier for an edge-configured pin
  function automatic logic edge_match(input logic was, input logic now,
                                      input logic dual, input logic pol);
    logic rise, fall;
    rise = !was && now;
    fall = was && !now;
    if (dual) return rise || fall;
    return pol ? rise : fall;
  endfunction

  // Level qualifier for a level-configured pin
  function automatic logic level_match(input logic now, input logic pol);
    return now == pol;
  endfunction

endpackage

// File: rtl/girq_sync.sv
module girq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= stg[LAST];
  end

  assign cur = stg[LAST];

  // The delayed copy must track the synchronized value one cycle later
  assert_prev_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> prev == $past(cur));
endmodule

// File: rtl/girq_regs.sv
module girq_regs
  import gpio_irq_pkg::*;
#(
  parameter int           W    = 8,
  parameter logic [W-1:0] CONN = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] sense,
  output logic [W-1:0] dual,
  output logic [W-1:0] pol,
  output logic [W-1:0] enable,
  output logic [W-1:0] clr_pulse
);
  logic [W-1:0] wd_conn;
  assign wd_conn = wdata & CONN;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense  <= '0;
      dual   <= '0;
      pol    <= '0;
      enable <= '0;
    end else if (wr) begin
      case (reg_sel_e'(addr))
        RA_SENSE:  sense  <= wd_conn;
        RA_DUAL:   dual   <= wd_conn;
        RA_POL:    pol    <= wd_conn;
        RA_ENABLE: enable <= wd_conn;
        default: ;
      endcase
    end
  end

  assign clr_pulse = (wr && reg_sel_e'(addr) == RA_CLEAR) ? wd_conn : '0;

  assert_reset_cfg_zero_R1: assert property (@(posedge clk)
    $past(rst) |-> (sense == '0 && dual == '0 && pol == '0 && enable == '0));

  assert_absent_cfg_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ((sense | dual | pol | enable) & ~CONN) == '0);
endmodule

// File: rtl/girq_detect.sv
module girq_detect
  import gpio_irq_pkg::*;
#(
  parameter int           W    = 8,
  parameter logic [W-1:0] CONN = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] sense,
  input  logic [W-1:0] dual,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] clr,
  output logic [W-1:0] raw,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] level_hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    if (CONN[i]) begin : g_live
      assign edge_hit[i]  = !sense[i] && edge_match(prev[i], cur[i], dual[i], pol[i]);
      assign level_hit[i] = sense[i] && level_match(cur[i], pol[i]);

      always_ff @(posedge clk) begin
        if (rst)               raw[i] <= 1'b0;
        else if (sense[i])     raw[i] <= level_hit[i];
        else if (edge_hit[i])  raw[i] <= 1'b1;
        else if (clr[i])       raw[i] <= 1'b0;
      end

      // An accepted edge always lands in status, even against a clear (R9)
      assert_edge_sets_R9: assert property (@(posedge clk) disable iff (rst)
        edge_hit[i] |=> raw[i]);

      assert_edge_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (!sense[i] && raw[i] && !clr[i]) |=> raw[i]);
    end else begin : g_absent
      assign edge_hit[i]  = 1'b0;
      assign level_hit[i] = 1'b0;
      assign raw[i]       = 1'b0;
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int               NPINS       = 8,
  parameter logic [NPINS-1:0] CONN_MASK   = '1,
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_in,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [NPINS-1:0] reg_wdata,
  output logic [NPINS-1:0] reg_rdata,
  output logic             irq_out
);
  logic [NPINS-1:0] pin_cur, pin_prev;
  logic [NPINS-1:0] sense, dual, pol, enable, clr_pulse;
  logic [NPINS-1:0] raw, edge_hit, level_hit, masked;

  girq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .cur(pin_cur), .prev(pin_prev)
  );

  girq_regs #(.W(NPINS), .CONN(CONN_MASK)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .sense(sense), .dual(dual), .pol(pol), .enable(enable), .clr_pulse(clr_pulse)
  );

  girq_detect #(.W(NPINS), .CONN(CONN_MASK)) u_detect (
    .clk(clk), .rst(rst), .cur(pin_cur), .prev(pin_prev),
    .sense(sense), .dual(dual), .pol(pol), .clr(clr_pulse),
    .raw(raw), .edge_hit(edge_hit), .level_hit(level_hit)
  );

  assign masked  = raw & enable;
  assign irq_out = |masked;

  always_comb begin
    case (reg_sel_e'(reg_addr))
      RA_SENSE:  reg_rdata = sense;
      RA_DUAL:   reg_rdata = dual;
      RA_POL:    reg_rdata = pol;
      RA_ENABLE: reg_rdata = enable;
      RA_RAW:    reg_rdata = raw;
      RA_MASKED: reg_rdata = masked;
      default:   reg_rdata = '0;
    endcase
  end

  assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> (enable != '0 && raw != '0));

  assert_absent_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata & ~CONN_MASK) == '0);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_out && raw == '0));
endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  localparam logic [7:0] CONN = 8'h3F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pad_in = '0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_out;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_sense, m_dual, m_pol, m_en, m_raw, m_pad;

  always #2 clk = ~clk;

  gpio_irq_unit #(.NPINS(8), .CONN_MASK(CONN), .SYNC_STAGES(2)) u_gpio_irq_unit (
    .clk(clk), .rst(rst), .pad_in(pad_in), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  // Bench restatement of the trigger rules, pin by pin
  function automatic logic [7:0] trig(input logic [7:0] o, input logic [7:0] n);
    logic [7:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      if (CONN[i] && !m_sense[i]) begin
        if (m_dual[i])      r[i] = o[i] ^ n[i];
        else if (m_pol[i])  r[i] = n[i] & ~o[i];
        else                r[i] = o[i] & ~n[i];
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] levels();
    return m_sense & ~(m_pad ^ m_pol) & CONN;
  endfunction

  task automatic refresh_level();
    m_raw = (m_raw & ~m_sense) | levels();
  endtask

  task automatic do_pad(input logic [7:0] n);
    logic [7:0] h;
    h = trig(m_pad, n);
    @(negedge clk);
    pad_in = n;
    m_pad = n;
    m_raw = m_raw | h;
    refresh_level();
    settle();
  endtask

  task automatic do_cfg(input logic [2:0] a, input logic [7:0] v);
    wr(a, v);
    case (a)
      3'd0: m_sense = v & CONN;
      3'd1: m_dual  = v & CONN;
      3'd2: m_pol   = v & CONN;
      3'd3: m_en    = v & CONN;
      3'd6: m_raw   = m_raw & ~(v & CONN & ~m_sense);
      default: ;
    endcase
    refresh_level();
    settle();
  endtask

  task automatic compare(input string tag);
    logic [7:0] v;
    rd(3'd4, v);
    check({tag, " raw R3 R4 R5 R6"}, v, m_raw);
    rd(3'd5, v);
    check({tag, " masked R7"}, v, m_raw & m_en);
    #0 check({tag, " irq R7"}, {7'd0, irq_out}, {7'd0, |(m_raw & m_en)});
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    void'($urandom(32'd1357));
    {m_sense, m_dual, m_pol, m_en, m_raw, m_pad} = '0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state, R10 empty addresses
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 R10 reset readback", v, 8'h00);
    end
    check("R1 irq after reset", {7'd0, irq_out}, 8'h00);

    // R10 readback, R8 absent bits dropped
    wr(3'd0, 8'hA5); wr(3'd1, 8'hFF); wr(3'd2, 8'h5A); wr(3'd3, 8'hC3);
    rd(3'd0, v); check("R10 sense readback R8", v, 8'h25);
    rd(3'd1, v); check("R10 dual readback R8", v, 8'h3F);
    rd(3'd2, v); check("R10 pol readback R8", v, 8'h1A);
    rd(3'd3, v); check("R10 enable readback R8", v, 8'h03);
    wr(3'd6, 8'hFF); rd(3'd6, v); check("R10 clear reads zero", v, 8'h00);
    for (int a = 0; a < 4; a++) wr(3'(a), 8'h00);
    wr(3'd6, 8'hFF);
    settle();

    // R2 latency: pin0 rising edge
    do_cfg(3'd2, 8'h01);
    @(negedge clk); reg_addr = 3'd4; pad_in = 8'h01;
    @(posedge clk); @(posedge clk); #1;
    check("R2 not yet after 2 edges", reg_rdata & 8'h01, 8'h00);
    @(posedge clk); #1;
    check("R2 set on 3rd edge", reg_rdata & 8'h01, 8'h01);
    m_pad = 8'h01; m_raw = 8'h01;
    settle();
    compare("R2");

    // R3 falling on pin0 ignored with pol=1, then pol=0 fires on fall
    do_cfg(3'd6, 8'h01); compare("R5 clear");
    do_pad(8'h00); compare("R3 fall ignored");
    check("R3 fall ignored bit", m_raw & 8'h01, 8'h00);
    do_cfg(3'd2, 8'h00); do_pad(8'h01); compare("R3 rise ignored pol0");
    do_pad(8'h00); compare("R3 fall fires pol0");
    do_cfg(3'd6, 8'h00); compare("R5 zero write keeps");

    // R4 dual edges on pin3, pol ignored
    do_cfg(3'd1, 8'h08); do_cfg(3'd2, 8'h08);
    do_pad(8'h08); compare("R4 rise");
    do_cfg(3'd6, 8'h08); do_pad(8'h00); compare("R4 fall");

    // R6 level on pin2 high, clear no effect; R7 irq
    do_cfg(3'd6, 8'hFF);
    do_cfg(3'd0, 8'h04); do_cfg(3'd2, 8'h0C); do_cfg(3'd3, 8'h04);
    do_pad(8'h04); compare("R6 high level");
    do_cfg(3'd6, 8'h04); compare("R6 clear no effect");
    check("R7 irq on level", {7'd0, irq_out}, 8'h01);
    // R11 switch level to edge keeps last value
    do_cfg(3'd0, 8'h00); compare("R11 keep after mode switch");
    do_pad(8'h00); do_cfg(3'd6, 8'hFF); compare("R11 cleared");

    // R8 absent pin7 level never shows
    do_cfg(3'd0, 8'hC0); do_pad(8'hC0); compare("R8 absent pins");
    do_cfg(3'd0, 8'h00); do_pad(8'h00); do_cfg(3'd6, 8'hFF);

    // R9 edge and clear on same edge: pin1 rising
    do_cfg(3'd2, 8'h02);
    @(negedge clk); pad_in = 8'h02;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h02;
    @(negedge clk); reg_wr = 1'b0; reg_addr = 3'd4;
    #1 check("R9 edge beats clear", reg_rdata & 8'h02, 8'h02);
    m_pad = 8'h02; m_raw = m_raw | 8'h02;
    settle(); compare("R9");

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 5)       do_pad(8'($urandom));
      else if (k < 8)  do_cfg(3'($urandom_range(0, 3)), 8'($urandom));
      else             do_cfg(3'd6, 8'($urandom));
      compare("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule